// File: doc/BRIEF.md
# Write-Protected Module Clock-Stop and Soft-Reset Controller

This block is a register file on a simple 32-bit memory-mapped bus. For every module of the chip it holds one clock-stop request bit and one soft-reset bit, grouped in banks of 32 modules. It drives one clock-enable line and one reset line per module. Any write that alters these bits is guarded: it lands only if the bus write just before it put the bitwise complement of the same data word into the protection register.

The reset bits are changed through two registers per bank. One sets the bits written as 1 and one clears the bits written as 1, so software never has to read, modify and write back. The stop bits are written directly. A read-only status copy of each stop bit follows its request only after a fixed number of cycles, so software polls the status until the module has settled. A guarded write that fails is dropped and raises a sticky error flag.

Top module: `modStopCtl`

## Requirements
- R1: After reset, every stop request bit and every stop status bit is 1, every module reset output is 1, every clock-enable output is 0 and the error flag (offset 0x004 bit 0) is 0.
- R2: A write to offset 0x000 stores an unlock word. A write to a guarded register takes effect only when the bus write just before it went to 0x000 with the bitwise inverse of its data. Offset 0x000 reads as zero.
- R3: A guarded write without a valid unlock changes nothing and sets the error flag. Writing 1 to bit 0 of offset 0x004 clears the flag and needs no unlock.
- R4: Any bus write, whatever its address, uses up a stored unlock. A guarded write that follows any other write is refused as in R3.
- R5: Offset 0x2C00+4n (bank n) is guarded. Each 1 bit written asserts that module's reset, and 0 bits leave their reset unchanged. A read returns the bank's current reset state.
- R6: Offset 0x2C80+4n is guarded. Each 1 bit written releases that module's reset, and 0 bits leave it unchanged. The register reads as zero.
- R7: Offset 0x2D00+4n is the guarded stop request (1 = stop, read back as written). Offset 0x2E00+4n is the read-only status. A status bit takes the request's value exactly STOP_DELAY cycles after the request changes, if the request holds steady. A write to the status register changes nothing and raises no error.
- R8: If a request bit returns to its status value before the delay ends, the status bit never moves. A request reversed on the very edge where the status would flip lets the status take the old request, then follow the new one STOP_DELAY cycles later.
- R9: For module bit b of bank n, clock-enable output index 32n+b is the inverse of its status bit, and reset output index 32n+b is its reset bit.
- R10: Offsets that are unmapped, misaligned or in a bank at or above NUM_BANKS read zero. Writes to them change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one write per high cycle |
| busAddr | input | 14 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| modClkEn | output | NUM_BANKS*32 | Per-module clock enable |
| modRstOut | output | NUM_BANKS*32 | Per-module reset, active high |

## Verification
Two events can land in the same cycle: a new guarded stop write and the delay counter for that bit running out. The bench clears a stop bit, waits, and times a second unlocked write that sets the bit again so its data edge is exactly STOP_DELAY cycles after the first. It then checks that the status takes the cleared value on that edge and returns to stopped STOP_DELAY cycles later. A reversal well before expiry is run as the contrast case, and the status must never move.

// File: rtl/modStopPkg.sv
`timescale 1ns/1ps
package modStopPkg;
  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 14;
  localparam int BANK_IDX_W = 5;   // banks 0..31 fit inside one 128-byte page

  localparam logic [ADDR_W-1:0] KEY_OFF = 14'h0000;
  localparam logic [ADDR_W-1:0] ERR_OFF = 14'h0004;

  // busAddr[13:7] selects a page, busAddr[6:2] the bank inside it
  localparam logic [6:0] PAGE_RST_SET = 7'h58;  // 0x2C00
  localparam logic [6:0] PAGE_RST_CLR = 7'h59;  // 0x2C80
  localparam logic [6:0] PAGE_STOP    = 7'h5A;  // 0x2D00
  localparam logic [6:0] PAGE_STAT    = 7'h5C;  // 0x2E00

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_ERR,
    RD_RST,
    RD_STOP,
    RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic                  setWr;
    logic                  clrWr;
    logic                  stopWr;
    logic [BANK_IDX_W-1:0] bank;
    rdSel_e                rdSel;
  } strobe_t;
endpackage

// File: rtl/modStopCtrl.sv
`timescale 1ns/1ps
module modStopCtrl import modStopPkg::*; #(
  parameter int NUM_BANKS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output strobe_t           str,
  output logic              errFlag
);
  logic [BUS_W-1:0]      keyQ;
  logic                  keyValidQ;
  logic                  errQ;
  logic [6:0]            page;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  inBank;
  logic                  isSet, isClr, isStop, isStat, isProt;
  logic                  keyOk, wrOk;

  assign page    = busAddr[13:7];
  assign bankIdx = busAddr[6:2];
  assign inBank  = (busAddr[1:0] == 2'b00) && (int'(bankIdx) < NUM_BANKS);
  assign isSet   = inBank && (page == PAGE_RST_SET);
  assign isClr   = inBank && (page == PAGE_RST_CLR);
  assign isStop  = inBank && (page == PAGE_STOP);
  assign isStat  = inBank && (page == PAGE_STAT);
  assign isProt  = isSet || isClr || isStop;
  assign keyOk   = keyValidQ && (keyQ == ~busWdata);
  assign wrOk    = busWe && isProt && keyOk;

  always_comb begin
    str.setWr  = wrOk && isSet;
    str.clrWr  = wrOk && isClr;
    str.stopWr = wrOk && isStop;
    str.bank   = bankIdx;
    if (busAddr == ERR_OFF)  str.rdSel = RD_ERR;
    else if (isSet)          str.rdSel = RD_RST;
    else if (isStop)         str.rdSel = RD_STOP;
    else if (isStat)         str.rdSel = RD_STAT;
    else                     str.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ      <= '0;
      keyValidQ <= 1'b0;
      errQ      <= 1'b0;
    end else if (busWe) begin
      if (busAddr == KEY_OFF) begin
        keyQ      <= busWdata;
        keyValidQ <= 1'b1;
      end else begin
        keyValidQ <= 1'b0;
      end
      if (isProt && !keyOk)
        errQ <= 1'b1;
      else if ((busAddr == ERR_OFF) && busWdata[0])
        errQ <= 1'b0;
    end
  end

  assign errFlag = errQ;

  AST_ERR_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errQ) |-> ($past(busWe) && ($past(busAddr) == ERR_OFF) && $past(busWdata[0]))); // R3

  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr != KEY_OFF)) |=> !keyValidQ); // R4
endmodule

// File: rtl/modStopData.sv
`timescale 1ns/1ps
module modStopData import modStopPkg::*; #(
  parameter int NUM_BANKS  = 12,
  parameter int STOP_DELAY = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    str,
  input  logic [BUS_W-1:0]           wdata,
  input  logic                       errFlag,
  output logic [BUS_W-1:0]           rdata,
  output logic [NUM_BANKS*BUS_W-1:0] clkEn,
  output logic [NUM_BANKS*BUS_W-1:0] rstOut
);
  localparam int CNT_W = (STOP_DELAY > 1) ? $clog2(STOP_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STOP_DELAY - 1);

  logic [NUM_BANKS-1:0][BUS_W-1:0]            rstQ;
  logic [NUM_BANKS-1:0][BUS_W-1:0]            stopQ;
  logic [NUM_BANKS-1:0][BUS_W-1:0]            statQ;
  logic [NUM_BANKS-1:0][BUS_W-1:0][CNT_W-1:0] cntQ;

  // control registers: reset set/clear and stop request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstQ  <= '1;
      stopQ <= '1;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (str.bank == BANK_IDX_W'(b)) begin
          if (str.setWr)  rstQ[b]  <= rstQ[b] | wdata;
          if (str.clrWr)  rstQ[b]  <= rstQ[b] & ~wdata;
          if (str.stopWr) stopQ[b] <= wdata;
        end
      end
    end
  end

  // per-bit settle counters: status copies the request after STOP_DELAY steady cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '1;
      cntQ  <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int i = 0; i < BUS_W; i++) begin
          if (statQ[b][i] == stopQ[b][i]) begin
            cntQ[b][i] <= '0;
          end else if (cntQ[b][i] == CNT_LAST) begin
            statQ[b][i] <= stopQ[b][i];
            cntQ[b][i]  <= '0;
          end else begin
            cntQ[b][i] <= cntQ[b][i] + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (str.bank == BANK_IDX_W'(b)) begin
        case (str.rdSel)
          RD_RST:  rdata = rstQ[b];
          RD_STOP: rdata = stopQ[b];
          RD_STAT: rdata = statQ[b];
          default: ;
        endcase
      end
    end
    if (str.rdSel == RD_ERR) rdata = {{(BUS_W-1){1'b0}}, errFlag};
  end

  assign clkEn  = ~statQ;
  assign rstOut = rstQ;

  AST_STAT_TAKES_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ ^ $past(statQ)) & (statQ ^ $past(stopQ))) == '0); // R7

  AST_STAT_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ ^ $past(statQ)) & ~($past(statQ) ^ $past(stopQ))) == '0); // R8

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!str.setWr && !str.clrWr) |=> $stable(rstQ)); // R5

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !str.stopWr |=> $stable(stopQ)); // R2
endmodule

// File: rtl/modStopCtl.sv
`timescale 1ns/1ps
module modStopCtl import modStopPkg::*; #(
  parameter int NUM_BANKS  = 12,
  parameter int STOP_DELAY = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [BUS_W-1:0]           busWdata,
  output logic [BUS_W-1:0]           busRdata,
  output logic [NUM_BANKS*BUS_W-1:0] modClkEn,
  output logic [NUM_BANKS*BUS_W-1:0] modRstOut
);
  strobe_t str;
  logic    errFlag;

  modStopCtrl #(.NUM_BANKS(NUM_BANKS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .str      (str),
    .errFlag  (errFlag)
  );

  modStopData #(.NUM_BANKS(NUM_BANKS), .STOP_DELAY(STOP_DELAY)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .wdata   (busWdata),
    .errFlag (errFlag),
    .rdata   (busRdata),
    .clkEn   (modClkEn),
    .rstOut  (modRstOut)
  );
endmodule

// File: tb/test_modStopCtl.sv
`timescale 1ns/1ps
module test_modStopCtl;
  localparam int NB = 12;
  localparam int W  = NB * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWe = 1'b0;
  logic [13:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [W-1:0]  modClkEn;
  logic [W-1:0]  modRstOut;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  modStopCtl #(.NUM_BANKS(NB), .STOP_DELAY(4)) i_modStopCtl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .modClkEn(modClkEn), .modRstOut(modRstOut)
  );

  always #10 clk = ~clk;

  function automatic logic [13:0] aSet(int n);  return 14'h2C00 + 14'(4*n); endfunction
  function automatic logic [13:0] aClr(int n);  return 14'h2C80 + 14'(4*n); endfunction
  function automatic logic [13:0] aStop(int n); return 14'h2D00 + 14'(4*n); endfunction
  function automatic logic [13:0] aStat(int n); return 14'h2E00 + 14'(4*n); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [13:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic protWrite(logic [13:0] a, logic [31:0] d);
    busWrite(14'h0000, ~d);
    busWrite(a, d);
  endtask

  task automatic busRead(logic [13:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(aStop(0), d);  check("R1 stop bank0", d, 32'hFFFF_FFFF);
    busRead(aStat(11), d); check("R1 status bank11", d, 32'hFFFF_FFFF);
    busRead(aSet(5), d);   check("R1 reset bank5", d, 32'hFFFF_FFFF);
    busRead(14'h0004, d);  check("R1 error flag", d, 32'h0);
    check("R1 clock enables low", 32'(modClkEn != '0), 32'h0);
    check("R1 resets high", 32'(modRstOut != '1), 32'h0);
  endtask

  task automatic testResetRegs();
    logic [31:0] d;
    protWrite(aClr(5), 32'h8000_0000);
    busRead(aSet(5), d);  check("R6 clear bit31 bank5", d, 32'h7FFF_FFFF);
    busRead(aClr(5), d);  check("R6 clear reg reads zero", d, 32'h0);
    check("R9 reset out 5/31", 32'(modRstOut[5*32+31]), 32'h0);
    busRead(14'h0004, d); check("R2 good unlock no error", d, 32'h0);
    busRead(14'h0000, d); check("R2 key reg reads zero", d, 32'h0);
    protWrite(aClr(11), 32'h000F_FFFF);
    protWrite(aSet(11), 32'h0000_0003);
    busRead(aSet(11), d); check("R5 set keeps zero bits", d, 32'hFFF0_0003);
    check("R9 reset out bank11", modRstOut[11*32 +: 32], 32'hFFF0_0003);
  endtask

  task automatic testBadKey();
    logic [31:0] d;
    busWrite(14'h0000, 32'h0000_1234);
    busWrite(aStop(0), 32'h0);
    busRead(aStop(0), d);  check("R3 wrong key ignored", d, 32'hFFFF_FFFF);
    busRead(14'h0004, d);  check("R3 error set", d, 32'h1);
    busWrite(14'h0004, 32'h1);
    busRead(14'h0004, d);  check("R3 error cleared", d, 32'h0);
    busWrite(aClr(0), 32'hFFFF_FFFF);
    busRead(aSet(0), d);   check("R3 no key ignored", d, 32'hFFFF_FFFF);
    busRead(14'h0004, d);  check("R3 error set again", d, 32'h1);
    busWrite(14'h0004, 32'h1);
  endtask

  task automatic testKeySpent();
    logic [31:0] d;
    busWrite(14'h0000, ~32'hFFFF_0000);
    busWrite(14'h3000, 32'h0);
    busWrite(aStop(1), 32'hFFFF_0000);
    busRead(aStop(1), d);  check("R4 spent key ignored", d, 32'hFFFF_FFFF);
    busRead(14'h0004, d);  check("R4 error set", d, 32'h1);
    busWrite(14'h0004, 32'h1);
    protWrite(aStat(1), 32'h0);
    busRead(aStat(1), d);  check("R7 status write ignored", d, 32'hFFFF_FFFF);
    busRead(14'h0004, d);  check("R7 status write no error", d, 32'h0);
  endtask

  task automatic testStopDelay();
    logic [31:0] d;
    protWrite(aStop(2), 32'hFFFF_FFFE);
    busRead(aStop(2), d);  check("R7 request reads back", d, 32'hFFFF_FFFE);
    idle(3);
    busRead(aStat(2), d);  check("R7 status still stopped", d, 32'hFFFF_FFFF);
    idle(1);
    busRead(aStat(2), d);  check("R7 status after delay", d, 32'hFFFF_FFFE);
    check("R9 clock enable 2/0", 32'(modClkEn[64]), 32'h1);
    protWrite(aStop(11), 32'h0);
    idle(4);
    check("R9 clock enables bank11", modClkEn[11*32 +: 32], 32'hFFFF_FFFF);
  endtask

  task automatic testReversal();
    logic [31:0] d;
    protWrite(aStop(3), 32'hFFFF_FFEF);       // data edge E0
    idle(2);                                  // E1, E2
    protWrite(aStop(3), 32'hFFFF_FFFF);       // key E3, data E4
    busRead(aStat(3), d);  check("R8 same-edge status takes old", d, 32'hFFFF_FFEF);
    idle(3);
    busRead(aStat(3), d);  check("R8 status holds before redo", d, 32'hFFFF_FFEF);
    idle(1);
    busRead(aStat(3), d);  check("R8 status back to stopped", d, 32'hFFFF_FFFF);
    protWrite(aStop(4), 32'hFFFF_FFFE);
    protWrite(aStop(4), 32'hFFFF_FFFF);
    busRead(aStat(4), d);  check("R8 early reversal mid", d, 32'hFFFF_FFFF);
    idle(6);
    busRead(aStat(4), d);  check("R8 early reversal end", d, 32'hFFFF_FFFF);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    logic [W-1:0] enSnap, rstSnap;
    busRead(14'h2D30, d);  check("R10 bank12 reads zero", d, 32'h0);
    busRead(14'h2D01, d);  check("R10 misaligned reads zero", d, 32'h0);
    busRead(14'h1000, d);  check("R10 hole reads zero", d, 32'h0);
    enSnap = modClkEn; rstSnap = modRstOut;
    protWrite(14'h2D30, 32'h0);
    protWrite(14'h2C31, 32'h0);
    protWrite(14'h2CB0, 32'hFFFF_FFFF);
    idle(6);
    check("R10 clock enables unchanged", 32'(modClkEn != enSnap), 32'h0);
    check("R10 resets unchanged", 32'(modRstOut != rstSnap), 32'h0);
    busRead(14'h0004, d);  check("R10 no error", d, 32'h0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testResetRegs();
    testBadKey();
    testKeySpent();
    testStopDelay();
    testReversal();
    testUnmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule